// File: doc/BRIEF.md
# Console Serial Port Register Front End

This block is the byte-wide register face of a simple console serial port on a memory-mapped bus. It masks each request address with a configurable mask. It then decodes the result into a data location, a command/pointer location, a status location, and two locations that accept writes and do nothing with them. The data location sends a byte on write and returns a received byte on read. Characters enter through a valid/ready receive handshake and leave through a valid/ready transmit handshake. Bit-level serialization, baud timing and FIFOs are handled elsewhere.

The block holds one received character. It fetches that character only when a status read finds the holding slot empty. It keeps a transmit interrupt that a pulse from the transmitter sets and a command byte clears. A one-shot pointer, armed by a command write, makes the next status read return an interrupt-cause vector in place of the line status. Misuse does not stop the block. Each kind of misuse raises a sticky error flag.

Top module: `console_regs`

## Requirements
- R1: The decoded offset is the request address ANDed with ADDR_MASK. Offset 0x8 is data, 0xB is command/pointer, 0xD is status, and 0x9 and 0xC are ignored locations. A read of any offset other than 0x8 or 0xD returns zero.
- R2: When the pointer is not armed, a status read returns 0x04, with bit 0 also set when a received character is pending.
- R3: rx_ready is high only during a status read that finds the holding slot empty. A character accepted in that cycle fills the slot and counts as pending for that same read.
- R4: Writing 0x03 to the command location arms the pointer. The next status read returns 0x10 if the transmit interrupt is pending, otherwise 0x20 if a received character is pending, otherwise 0x00. That read disarms the pointer.
- R5: A one-cycle pulse on tx_irq_set sets the transmit interrupt, which stays set until the command byte 0x28 is written. If the pulse and the acknowledge fall in the same cycle, the pulse wins.
- R6: err goes high and stays high until reset after any of these: acknowledging (0x28) with no transmit interrupt pending, reading data while the slot is empty, or writing data while an earlier byte is still waiting on the transmit handshake.
- R7: A data read returns the held character and empties the slot. A data read of an empty slot returns 0x00.
- R8: A data write puts bits 7:0 of the write data on tx_data and raises tx_valid. Both hold steady until tx_ready is seen. A write made while a byte is still waiting is dropped.
- R9: Writes to 0x9 and 0xC, and command bytes other than 0x03 and 0x28, change no output and no later read result. A command write does replace an armed pointer.
- R10: Every read gives bus_rvalid one cycle later, with the byte in bits 7:0 and all higher bits zero.
- R11: irq is high exactly when the transmit interrupt is pending or the holding slot is full.
- R12: Reset clears the pointer, the transmit interrupt, the slot-full flag, the transmit request, the error flag and bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Request address, masked by ADDR_MASK |
| bus_wdata | input | DATA_W | Write data; bits 7:0 are used |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | DATA_W | Read data, zero above bit 7 |
| rx_valid | input | 1 | Character source has a byte |
| rx_data | input | 8 | Character offered by the source |
| rx_ready | output | 1 | Block takes the offered character |
| tx_valid | output | 1 | Byte waiting for the sink |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_irq_set | input | 1 | Transmitter-ready pulse; sets the transmit interrupt |
| irq | output | 1 | Interrupt request |
| err | output | 1 | Sticky misuse flag |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 64-bit data bus and a mask of 0x0F. The narrow mask lets randomly chosen high address bits alias onto the five decoded offsets, so address decode is exercised on every random access. The wide data bus makes the zero fill above bit 7 visible on every read. Random command bytes, same-cycle transmitter pulses and acknowledges, and a receive source that is only sometimes valid reach each pointer, slot and error path. Periodic resets clear the sticky error flag so that later misuse can be seen again.

// File: rtl/cons_pkg.sv
`timescale 1ns/1ps
package cons_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_CMD,
    SEL_STAT,
    SEL_IGN
  } cons_sel_e;

  localparam logic [7:0] OFS_DATA  = 8'h08;
  localparam logic [7:0] OFS_DIVH  = 8'h09;
  localparam logic [7:0] OFS_CMD   = 8'h0B;
  localparam logic [7:0] OFS_MODEM = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h0D;

  localparam logic [7:0] CMD_PTR   = 8'h03;
  localparam logic [7:0] CMD_TXACK = 8'h28;

  localparam logic [7:0] STAT_BASE = 8'h04;
  localparam logic [7:0] VEC_TX    = 8'h10;
  localparam logic [7:0] VEC_RX    = 8'h20;
endpackage

// File: rtl/cons_decode.sv
`timescale 1ns/1ps
module cons_decode
  import cons_pkg::*;
#(
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  ADDR_MASK = 'h0F
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output cons_sel_e         sel
);
  logic [ADDR_W-1:0] offset;

  assign offset = bus_addr & ADDR_MASK;

  always_comb begin
    if (offset == ADDR_W'(OFS_DATA))                                     sel = SEL_DATA;
    else if (offset == ADDR_W'(OFS_CMD))                                 sel = SEL_CMD;
    else if (offset == ADDR_W'(OFS_STAT))                                sel = SEL_STAT;
    else if (offset == ADDR_W'(OFS_DIVH) || offset == ADDR_W'(OFS_MODEM)) sel = SEL_IGN;
    else                                                                 sel = SEL_NONE;
  end
endmodule

// File: rtl/cons_rx_slot.sv
`timescale 1ns/1ps
module cons_rx_slot (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       full,
  output logic       rx_pending,
  output logic [7:0] hold_data,
  output logic       empty_rd_err
);
  logic       take;
  logic       full_d;
  logic [7:0] hold_d;
  logic       hold_en;

  assign rx_ready     = stat_rd & ~full;
  assign take         = rx_ready & rx_valid;
  assign rx_pending   = full | take;
  assign empty_rd_err = data_rd & ~full;
  assign hold_en      = take;

  always_comb begin
    full_d = full;
    if (take)    full_d = 1'b1;
    if (data_rd) full_d = 1'b0;
    hold_d = rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_data <= hold_d;
  end
endmodule

// File: rtl/cons_int_ptr.sv
`timescale 1ns/1ps
module cons_int_ptr
  import cons_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       stat_rd,
  input  logic       tx_set,
  output logic       ptr_armed,
  output logic       tx_int,
  output logic       ack_err
);
  logic [7:0] ptr_q, ptr_d;
  logic       ptr_en;
  logic       ack;
  logic       tx_int_d;

  assign ptr_armed = (ptr_q == CMD_PTR);
  assign ack       = cmd_wr & (cmd_byte == CMD_TXACK);
  assign ack_err   = ack & ~tx_int;
  assign ptr_en    = cmd_wr | (stat_rd & ptr_armed);

  always_comb begin
    ptr_d    = cmd_wr ? cmd_byte : 8'h00;
    tx_int_d = tx_set | (tx_int & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= 8'h00;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_int <= 1'b0;
    else        tx_int <= tx_int_d;
  end
endmodule

// File: rtl/cons_tx_port.sv
`timescale 1ns/1ps
module cons_tx_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_wr,
  input  logic [7:0] wbyte,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       busy_err
);
  logic busy;
  logic load;
  logic valid_d;

  assign busy     = tx_valid & ~tx_ready;
  assign load     = data_wr & ~busy;
  assign busy_err = data_wr & busy;

  always_comb begin
    if (load)          valid_d = 1'b1;
    else if (tx_ready) valid_d = 1'b0;
    else               valid_d = tx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid <= 1'b0;
    else        tx_valid <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) tx_data <= wbyte;
  end
endmodule

// File: rtl/console_regs.sv
`timescale 1ns/1ps
module console_regs
  import cons_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 64,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              tx_irq_set,
  output logic              irq,
  output logic              err
);
  localparam int PAD_W = DATA_W - 8;

  cons_sel_e  sel;
  logic       rd, wr;
  logic       stat_rd, data_rd, cmd_wr, data_wr;
  logic       full, rx_pending, empty_rd_err;
  logic [7:0] hold_data;
  logic       ptr_armed, tx_int, ack_err, busy_err;
  logic [7:0] wbyte, rd_byte;
  logic       err_d;
  logic       wdata_unused;

  assign wbyte        = bus_wdata[7:0];
  assign wdata_unused = ^bus_wdata[DATA_W-1:8];
  assign rd           = bus_en & ~bus_we;
  assign wr           = bus_en & bus_we;
  assign stat_rd      = rd & (sel == SEL_STAT);
  assign data_rd      = rd & (sel == SEL_DATA);
  assign cmd_wr       = wr & (sel == SEL_CMD);
  assign data_wr      = wr & (sel == SEL_DATA);

  cons_decode #(.ADDR_W(ADDR_W), .ADDR_MASK(ADDR_MASK)) u_dec (
    .bus_addr (bus_addr),
    .sel      (sel)
  );

  cons_rx_slot u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_rd      (stat_rd),
    .data_rd      (data_rd),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .full         (full),
    .rx_pending   (rx_pending),
    .hold_data    (hold_data),
    .empty_rd_err (empty_rd_err)
  );

  cons_int_ptr u_ip (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_byte  (wbyte),
    .stat_rd   (stat_rd),
    .tx_set    (tx_irq_set),
    .ptr_armed (ptr_armed),
    .tx_int    (tx_int),
    .ack_err   (ack_err)
  );

  cons_tx_port u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .wbyte    (wbyte),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .busy_err (busy_err)
  );

  always_comb begin
    rd_byte = 8'h00;
    if (data_rd) begin
      rd_byte = full ? hold_data : 8'h00;
    end else if (stat_rd) begin
      if (ptr_armed) begin
        if (tx_int)          rd_byte = VEC_TX;
        else if (rx_pending) rd_byte = VEC_RX;
        else                 rd_byte = 8'h00;
      end else begin
        rd_byte = STAT_BASE | {7'b0, rx_pending};
      end
    end
    err_d = err | ack_err | empty_rd_err | busy_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      err        <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      err        <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd) bus_rdata <= {{PAD_W{1'b0}}, rd_byte};
  end

  assign irq = tx_int | full;
endmodule

// File: rtl/cons_regs_chk.sv
`timescale 1ns/1ps
module cons_regs_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_irq_set,
  input logic              irq,
  input logic              err
);
  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid);

  // R10
  rdata_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> ((bus_rdata >> 8) == '0));

  // R3
  rx_ready_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (bus_en && !bus_we));

  // R5
  tx_pulse_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_set |=> irq);
endmodule

bind console_regs cons_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_rvalid (bus_rvalid),
  .bus_rdata  (bus_rdata),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_irq_set (tx_irq_set),
  .irq        (irq),
  .err        (err)
);

// File: tb/console_regs_test.sv
`timescale 1ns/1ps
module console_regs_test;
  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [11:0] bus_addr;
  logic [63:0] bus_wdata;
  logic        bus_rvalid;
  logic [63:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;
  logic        tx_irq_set;
  logic        irq, err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit       m_tx_int, m_full, m_err, m_txv;
  bit [7:0] m_hold, m_ptr, m_txd;

  console_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_irq_set(tx_irq_set), .irq(irq), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_read(bit stat_rd, bit data_rd, bit rxp);
    if (data_rd)      return m_full ? m_hold : 8'h00;
    if (!stat_rd)     return 8'h00;
    if (m_ptr == 8'h03) return m_tx_int ? 8'h10 : (rxp ? 8'h20 : 8'h00);
    return 8'h04 | {7'b0, rxp};
  endfunction

  // Called at a falling edge; returns at a falling edge.
  task automatic op(input bit en, input bit we, input logic [11:0] addr,
                    input logic [63:0] wd, input bit set, input bit trdy);
    logic [7:0] off;
    bit stat_rd, data_rd, cmd_wr, data_wr, exp_rxr, take, rxp, busy;
    bit [7:0] eb;
    string tag;
    bus_en = en; bus_we = we; bus_addr = addr; bus_wdata = wd;
    tx_irq_set = set; tx_ready = trdy;
    off     = addr[7:0] & 8'h0F;
    stat_rd = en && !we && off == 8'h0D;
    data_rd = en && !we && off == 8'h08;
    cmd_wr  = en && we && off == 8'h0B;
    data_wr = en && we && off == 8'h08;
    #1;
    exp_rxr = stat_rd && !m_full;
    chk("R3 rx_ready", {63'b0, rx_ready}, {63'b0, exp_rxr});
    take = exp_rxr && rx_valid;
    rxp  = m_full || take;
    eb   = exp_read(stat_rd, data_rd, rxp);
    tag  = data_rd ? "R7 data read" : (stat_rd ? ((m_ptr == 8'h03) ? "R4 vector read" : "R2 status read") : "R1 other read");
    busy = m_txv && !trdy;
    if (data_rd && !m_full) m_err = 1;
    if (cmd_wr && wd[7:0] == 8'h28 && !m_tx_int) m_err = 1;
    if (data_wr && busy) m_err = 1;
    if (data_wr && !busy) begin m_txv = 1; m_txd = wd[7:0]; end
    else if (trdy) m_txv = 0;
    if (set) m_tx_int = 1;
    else if (cmd_wr && wd[7:0] == 8'h28) m_tx_int = 0;
    if (cmd_wr) m_ptr = wd[7:0];
    else if (stat_rd && m_ptr == 8'h03) m_ptr = 8'h00;
    if (take) begin m_full = 1; m_hold = rx_data; end
    if (data_rd) m_full = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 rvalid", {63'b0, bus_rvalid}, {63'b0, (en && !we)});
    if (en && !we) chk({tag, " (R10 zero fill)"}, bus_rdata, {56'b0, eb});
    chk("R8 tx_valid", {63'b0, tx_valid}, {63'b0, m_txv});
    if (m_txv) chk("R8 tx_data", {56'b0, tx_data}, {56'b0, m_txd});
    chk("R11 irq", {63'b0, irq}, {63'b0, (m_tx_int || m_full)});
    chk("R6 err", {63'b0, err}, {63'b0, m_err});
    bus_en = 0; tx_irq_set = 0;
    if (take) rx_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; bus_en = 0; tx_irq_set = 0; tx_ready = 0; rx_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_tx_int = 0; m_full = 0; m_err = 0; m_txv = 0; m_ptr = 0;
    @(negedge clk);
    chk("R12 reset rvalid", {63'b0, bus_rvalid}, 64'd0);
    chk("R12 reset tx_valid", {63'b0, tx_valid}, 64'd0);
    chk("R12 reset irq", {63'b0, irq}, 64'd0);
    chk("R12 reset err", {63'b0, err}, 64'd0);
    chk("R12 reset rx_ready", {63'b0, rx_ready}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bus_addr = 0; bus_wdata = 0; rx_data = 0; bus_en = 0; bus_we = 0;
    tx_ready = 0; tx_irq_set = 0; rx_valid = 0; rst_n = 0;
    do_reset();
    // status with no character offered
    op(1, 0, 12'h00D, 0, 0, 0);
    // character offered, fetched by status read
    rx_valid = 1; rx_data = 8'h41;
    op(1, 0, 12'h00D, 0, 0, 0);
    op(1, 0, 12'h00D, 0, 0, 0);
    // data read through an aliased address
    op(1, 0, 12'h3F8, 0, 0, 0);
    chk("R1 alias 0x3F8 decodes as data", bus_rdata, 64'h41);
    // transmitter pulse, then pointer vector
    op(0, 0, 12'h000, 0, 1, 0);
    op(1, 1, 12'h00B, 64'h03, 0, 0);
    op(1, 0, 12'h00D, 0, 0, 0);
    chk("R4 tx vector", bus_rdata, 64'h10);
    op(1, 0, 12'h00D, 0, 0, 0);
    chk("R4 pointer one-shot", bus_rdata, 64'h04);
    op(1, 1, 12'h00B, 64'h28, 0, 0);
    chk("R5 ack clears tx interrupt", {63'b0, irq}, 64'd0);
    // ignored writes
    op(1, 1, 12'h009, 64'hFF, 0, 0);
    op(1, 1, 12'h00C, 64'hFF, 0, 0);
    op(1, 1, 12'h00B, 64'h12, 0, 0);
    chk("R9 ignored writes send nothing", {63'b0, tx_valid}, 64'd0);
    op(1, 0, 12'h00D, 0, 0, 0);
    chk("R9 status unchanged", bus_rdata, 64'h04);
    // transmit handshake
    op(1, 1, 12'h008, 64'h1AB, 0, 0);
    op(0, 0, 12'h000, 0, 0, 0);
    op(0, 0, 12'h000, 0, 0, 1);
    // rx vector and empty vector
    rx_valid = 1; rx_data = 8'h5A;
    op(1, 1, 12'h00B, 64'h03, 0, 0);
    op(1, 0, 12'h00D, 0, 0, 0);
    op(1, 1, 12'h00B, 64'h03, 0, 0);
    op(1, 0, 12'h008, 0, 0, 0);
    op(1, 0, 12'h00D, 0, 0, 0);
    // pulse and ack together: pulse wins
    op(0, 0, 12'h000, 0, 1, 0);
    op(1, 1, 12'h00B, 64'h28, 1, 0);
    chk("R5 set beats ack", {63'b0, irq}, 64'd1);
    // misuse: data write while waiting, then empty read, ack with none
    op(1, 1, 12'h00B, 64'h28, 0, 0);
    op(1, 1, 12'h008, 64'h11, 0, 0);
    op(1, 1, 12'h008, 64'h22, 0, 0);
    op(0, 0, 12'h000, 0, 0, 1);
    do_reset();
    op(1, 0, 12'h008, 0, 0, 0);
    do_reset();
    op(1, 1, 12'h00B, 64'h28, 0, 0);
    // random phase
    void'($urandom(32'd20240613));
    for (int blk = 0; blk < 20; blk++) begin
      do_reset();
      for (int i = 0; i < 80; i++) begin
        logic [11:0] a;
        logic [7:0]  o;
        logic [63:0] w;
        int unsigned pick;
        pick = $urandom_range(0, 6);
        case (pick)
          0: o = 8'h08; 1: o = 8'h0B; 2, 3: o = 8'h0D;
          4: o = 8'h09; 5: o = 8'h0C; default: o = 8'h05;
        endcase
        a = {$urandom_range(0, 255), 4'h0} | {4'h0, o};
        w = {$urandom, $urandom};
        if (o == 8'h0B) begin
          case ($urandom_range(0, 4))
            0: w[7:0] = 8'h03; 1: w[7:0] = 8'h28; 2: w[7:0] = 8'h12;
            3: w[7:0] = 8'h00; default: ;
          endcase
        end
        if (!rx_valid && $urandom_range(0, 2) == 0) begin
          rx_valid = 1; rx_data = 8'($urandom);
        end
        op($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, a, w,
           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule